// File: doc/BRIEF.md
# Clock Postscaler with Reference-Loss Fallback

This block is the digital back end of a clock generator for a signal-processing controller. It takes two clocks. The first is a slow reference from the oscillator. The second is a fast clock from a frequency-multiplying loop that runs at eight times the reference. From these it builds the system clock. A 3-bit code picks a power-of-two division of the fast clock. A select bit then routes either the reference path or the divided fast path to the output. Each path is halved before the switch, so the system clock always has a 50% duty cycle at half the rate of the chosen double-rate source.

The source switch is break-before-make. Each side owns a short enable shift chain, clocked on the falling edge of that side's own half-rate clock. A side turns on only after the other side has turned off, so no partial pulse reaches `sys_clk`.

A watchdog runs on the fast clock and looks for rising reference edges. If it sees none for a set number of fast cycles, it raises a sticky flag and clears the PLL select. The PLL side then drops out, and the output stays low until the reference comes back. A single control word, written from the fast clock domain, holds three fields: the select bit, the postscaler code and the PLL power-down bit.

Top module: `clk_postscale_top`

## Requirements
- R1: After reset, `reg_rdata` reads 0x10 (PLL power-down bit 4 set, postscaler code 0, select bit 0) and `loss_flag` is 0.
- R2: With the reference path selected, `sys_clk` has a period of two reference periods and is high for exactly half of it.
- R3: The control word holds the select bit in bit 0, the postscaler code in bits 3:1 and the power-down bit in bit 4. With the PLL path active and code c in 0..5, `sys_clk` has a period of 2×2^c fast cycles and a 50% duty cycle.
- R4: Codes 6 and 7 give the same output as code 5, which is a division by 32.
- R5: A new postscaler code takes effect only when the current division count reaches its terminal value. The half-period in progress completes at the old length.
- R6: Writing select = 1 has no effect if the written word sets power-down or if `pll_lock` is low. The select bit reads back 0 and `sys_clk` stays at the reference rate. A low `pll_lock` clears the select bit on the next cycle.
- R7: While the source is switching, every high pulse on `sys_clk` is a full high phase of one source's half-rate clock. The two side enables are never on together.
- R8: When no rising reference edge is seen for 64 fast cycles, `loss_flag` goes to 1, the select bit clears on the next cycle, and `sys_clk` stays low while the reference is absent.
- R9: `loss_flag` stays set until reset, and select writes are ignored while it is set. When the reference returns, the reference path drives `sys_clk` again. Reset clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast clock from the PLL; also clocks the control word and the watchdog |
| osc_clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| pll_lock | input | 1 | PLL lock indication; the PLL path cannot be selected while it is low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 5 | Control word to write: bit 0 select, bits 3:1 postscaler code, bit 4 power-down |
| reg_rdata | output | 5 | Current control word |
| loss_flag | output | 1 | Sticky indication that the reference has been lost |
| sys_clk | output | 1 | 50% duty system clock |

## Verification
The bench changes the postscaler code partway through a long half-period. A divider that loaded the code at once would cut that phase short, and the bench checks that the phase keeps its old length. It switches between two sources of equal rate and unrelated phase, and measures every high pulse in the window: a mux without the handshake would let a clipped pulse or an overlapped pulse through. It stops the reference with the PLL path active and watches for a flag that fires too early or too late, a select bit that is not cleared, or an output that keeps toggling. It then writes select = 1 again and restores the reference, which catches a flag that is not sticky or a reference path that never comes back.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
  localparam int CODE_W      = 3;
  localparam int MAX_SHIFT   = 5;
  localparam int CNT_W       = MAX_SHIFT;
  localparam int LOSS_LIMIT  = 64;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic              pll_off;
    logic [CODE_W-1:0] ps_code;
    logic              use_pll;
  } ctrl_t;

  localparam int    CTRL_W     = $bits(ctrl_t);
  localparam ctrl_t CTRL_RESET = '{pll_off: 1'b1, ps_code: '0, use_pll: 1'b0};

  // Terminal count for a code; codes above MAX_SHIFT saturate.
  function automatic logic [CNT_W-1:0] last_count(input logic [CODE_W-1:0] code);
    int             sh;
    logic [CNT_W:0] span;
    sh   = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
    span = (CNT_W+1)'(1) << sh;
    return CNT_W'(span - (CNT_W+1)'(1));
  endfunction
endpackage

// File: rtl/cg_ctrl_reg.sv
`timescale 1ns/1ps
module cg_ctrl_reg
  import cg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  lock,
  input  logic  loss,
  output ctrl_t ctrl
);
  ctrl_t nxt;

  always_comb begin
    nxt = wr_en ? wr_val : ctrl;
    // PLL path is refused while powered down, unlocked or after reference loss
    if (nxt.pll_off || !lock || loss) nxt.use_pll = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= CTRL_RESET;
    else        ctrl <= nxt;
  end
endmodule

// File: rtl/cg_postscaler.sv
`timescale 1ns/1ps
module cg_postscaler
  import cg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_req,
  output logic              half_clk
);
  logic [CODE_W-1:0] code_act;
  logic [CNT_W-1:0]  cnt;
  logic              wrap;

  assign wrap = (cnt == last_count(code_act));

  // The requested code is sampled only at wrap, so no phase is shortened.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      code_act <= '0;
      half_clk <= 1'b0;
    end else if (wrap) begin
      cnt      <= '0;
      code_act <= code_req;
      half_clk <= ~half_clk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cg_ref_watch.sv
`timescale 1ns/1ps
module cg_ref_watch #(
  parameter int LIMIT  = 64,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic lost
);
  localparam int W = $clog2(LIMIT + 1);

  logic [STAGES-1:0] sync;
  logic              seen_q;
  logic [W-1:0]      idle;
  logic              ref_rise;

  assign ref_rise = sync[STAGES-1] & ~seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= '0;
      seen_q <= 1'b0;
      idle   <= '0;
      lost   <= 1'b0;
    end else begin
      sync   <= {sync[STAGES-2:0], ref_clk};
      seen_q <= sync[STAGES-1];
      if (ref_rise)              idle <= '0;
      else if (idle != W'(LIMIT)) idle <= idle + 1'b1;
      if (!ref_rise && idle == W'(LIMIT - 1)) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/cg_mux_leg.sv
`timescale 1ns/1ps
module cg_mux_leg #(
  parameter bit RESET_ON = 1'b0,
  parameter int STAGES   = 2
) (
  input  logic leg_clk,
  input  logic rst_n,
  input  logic want,
  input  logic peer_en,
  output logic leg_en
);
  logic [STAGES-1:0] sh;

  // Falling-edge chain: the enable changes only while this side's clock is low.
  always_ff @(negedge leg_clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RESET_ON}};
    else        sh <= {sh[STAGES-2:0], want & ~peer_en};
  end

  assign leg_en = sh[STAGES-1];
endmodule

// File: rtl/clk_postscale_top.sv
`timescale 1ns/1ps
module clk_postscale_top
  import cg_pkg::*;
#(
  parameter int LOSS_CYCLES = LOSS_LIMIT,
  parameter int SYNC_DEPTH  = SYNC_STAGES
) (
  input  logic              clk_fast,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              pll_lock,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              loss_flag,
  output logic              sys_clk
);
  ctrl_t ctrl;
  logic  pll_half;
  logic  osc_half;
  logic  en_pll;
  logic  en_osc;

  cg_ctrl_reg u_ctrl (
    .clk    (clk_fast),
    .rst_n  (rst_n),
    .wr_en  (reg_wr),
    .wr_val (ctrl_t'(reg_wdata)),
    .lock   (pll_lock),
    .loss   (loss_flag),
    .ctrl   (ctrl)
  );

  cg_ref_watch #(.LIMIT(LOSS_CYCLES), .STAGES(SYNC_DEPTH)) u_watch (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .ref_clk (osc_clk),
    .lost    (loss_flag)
  );

  cg_postscaler u_ps (
    .clk      (clk_fast),
    .rst_n    (rst_n),
    .code_req (ctrl.ps_code),
    .half_clk (pll_half)
  );

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) osc_half <= 1'b0;
    else        osc_half <= ~osc_half;
  end

  cg_mux_leg #(.RESET_ON(1'b0), .STAGES(SYNC_DEPTH)) u_leg_pll (
    .leg_clk (pll_half),
    .rst_n   (rst_n),
    .want    (ctrl.use_pll),
    .peer_en (en_osc),
    .leg_en  (en_pll)
  );

  cg_mux_leg #(.RESET_ON(1'b1), .STAGES(SYNC_DEPTH)) u_leg_osc (
    .leg_clk (osc_half),
    .rst_n   (rst_n),
    .want    (~ctrl.use_pll),
    .peer_en (en_pll),
    .leg_en  (en_osc)
  );

  assign reg_rdata = ctrl;
  assign sys_clk   = (pll_half & en_pll) | (osc_half & en_osc);
endmodule

// File: rtl/cg_checker.sv
`timescale 1ns/1ps
module cg_checker
  import cg_pkg::*;
(
  input logic clk_fast,
  input logic rst_n,
  input logic pll_lock,
  input logic loss_flag,
  input logic use_pll,
  input logic pll_half,
  input logic en_pll,
  input logic en_osc
);
  logic       half_d;
  logic       armed;
  logic [7:0] gap;
  logic [8:0] gap_p1;
  logic       toggled;

  assign toggled = (pll_half != half_d);
  assign gap_p1  = {1'b0, gap} + 9'd1;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      half_d <= 1'b0;
      armed  <= 1'b0;
      gap    <= '0;
    end else begin
      half_d <= pll_half;
      if (toggled) begin
        gap   <= '0;
        armed <= 1'b1;
      end else if (gap != 8'hFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R3, R4, R5: every half-period of the divided clock is a whole power of two
  assert_pow2_gap_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (armed && toggled) |-> ($countones(gap_p1) == 1 && gap_p1 <= 9'(1 << MAX_SHIFT)));

  assert_enables_exclusive_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(en_pll && en_osc));

  assert_lock_gate_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !pll_lock |=> !use_pll);

  assert_loss_fallback_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    loss_flag |=> !use_pll);

  assert_loss_sticky_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    loss_flag |=> loss_flag);
endmodule

bind clk_postscale_top cg_checker u_chk (
  .clk_fast  (clk_fast),
  .rst_n     (rst_n),
  .pll_lock  (pll_lock),
  .loss_flag (loss_flag),
  .use_pll   (reg_rdata[0]),
  .pll_half  (pll_half),
  .en_pll    (en_pll),
  .en_osc    (en_osc)
);

// File: tb/clk_postscale_top_bench.sv
`timescale 1ns/1ps
module clk_postscale_top_bench;
  import cg_pkg::*;

  logic              clk_fast  = 1'b0;
  logic              osc_clk   = 1'b0;
  logic              rst_n     = 1'b0;
  logic              pll_lock  = 1'b0;
  logic              reg_wr    = 1'b0;
  logic [CTRL_W-1:0] reg_wdata = '0;
  logic [CTRL_W-1:0] reg_rdata;
  logic              loss_flag;
  logic              sys_clk;

  int n_chk   = 0;
  int n_fail  = 0;
  bit osc_run = 1'b1;
  bit done    = 1'b0;

  // 125 MHz fast clock; reference at one eighth of it
  always #4 clk_fast = ~clk_fast;
  initial forever begin
    #32;
    if (osc_run) osc_clk = ~osc_clk;
  end

  clk_postscale_top u_clk_postscale_top (
    .clk_fast  (clk_fast),
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .pll_lock  (pll_lock),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .loss_flag (loss_flag),
    .sys_clk   (sys_clk)
  );

  typedef struct {
    longint per;
    string  req;
  } exp_t;
  exp_t sb_q[$];
  int   sb_pending = 0;

  task automatic check(input string req, input longint act, input longint exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [CTRL_W-1:0] ctl(input bit off, input int code, input bit sel);
    return {off, CODE_W'(code), sel};
  endfunction

  task automatic wr(input logic [CTRL_W-1:0] d);
    @(negedge clk_fast);
    reg_wr    = 1'b1;
    reg_wdata = d;
    @(negedge clk_fast);
    reg_wr = 1'b0;
  endtask

  // Driver side of the scoreboard: queue an expected period, wait for it to be consumed
  task automatic push_exp(input longint per, input string req);
    sb_q.push_back('{per, req});
    sb_pending++;
    wait (sb_pending == 0);
  endtask

  // Monitor: measures one full period and its high phase per queued item
  initial begin
    exp_t   e;
    longint t0, th, t1;
    forever begin
      wait (sb_pending != 0);
      e = sb_q.pop_front();
      @(posedge sys_clk); t0 = $time;
      @(negedge sys_clk); th = $time;
      @(posedge sys_clk); t1 = $time;
      check({e.req, " period"}, t1 - t0, e.per);
      check({e.req, " high phase"}, th - t0, e.per / 2);
      sb_pending--;
    end
  end

  // Switch window monitor: every high pulse must be a full 64 ns phase
  bit    win_on = 1'b0;
  string win_req = "";
  int    win_pulses = 0;
  initial begin
    longint tr;
    forever begin
      @(posedge sys_clk); tr = $time;
      @(negedge sys_clk);
      if (win_on) begin
        win_pulses++;
        check(win_req, $time - tr, 64);
      end
    end
  end

  int rises = 0;
  initial forever begin
    @(posedge sys_clk);
    rises++;
  end

  initial begin
    repeat (150000) @(posedge clk_fast);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    longint t0, t1, t2;
    int     r0;
    repeat (5) @(negedge clk_fast);
    rst_n = 1'b1;
    @(negedge clk_fast);
    check("R1 control word after reset", reg_rdata, 5'h10);
    check("R1 loss flag after reset", loss_flag, 0);
    push_exp(128, "R2 reference path after reset");

    // R3 / R4: sweep every code on the PLL path
    pll_lock = 1'b1;
    for (int c = 0; c < 8; c++) begin
      wr(ctl(1'b0, c, 1'b1));
      check(c > 5 ? "R4 select accepted" : "R3 select accepted", reg_rdata, ctl(1'b0, c, 1'b1));
      #3000;
      if (c > 5) push_exp(512, "R4 reserved code");
      else       push_exp(longint'(16) << c, "R3 postscaled PLL path");
    end

    // R5: code change in the middle of a 32-cycle phase
    wr(ctl(1'b0, 5, 1'b1));
    #3000;
    @(posedge sys_clk); t0 = $time;
    repeat (5) @(negedge clk_fast);
    wr(ctl(1'b0, 0, 1'b1));
    @(negedge sys_clk); t1 = $time;
    check("R5 phase in progress keeps old length", t1 - t0, 256);
    @(posedge sys_clk); t2 = $time;
    check("R5 next phase uses new code", t2 - t1, 8);

    // R6: refused selections
    wr(ctl(1'b1, 0, 1'b1));
    check("R6 select with power-down reads back", reg_rdata, ctl(1'b1, 0, 1'b0));
    #3000;
    push_exp(128, "R6 power-down keeps reference path");
    pll_lock = 1'b0;
    wr(ctl(1'b0, 0, 1'b1));
    check("R6 select without lock reads back", reg_rdata, ctl(1'b0, 0, 1'b0));
    #3000;
    push_exp(128, "R6 unlocked keeps reference path");
    pll_lock = 1'b1;

    // R7: switch between equal-rate sources in both directions
    win_req = "R7 high pulse during switch to PLL";
    win_pulses = 0;
    win_on = 1'b1;
    wr(ctl(1'b0, 3, 1'b1));
    #3000;
    win_on = 1'b0;
    check("R7 pulses seen during switch to PLL", win_pulses > 0, 1);
    push_exp(128, "R7 PLL path after switch");
    win_req = "R7 high pulse during switch to reference";
    win_pulses = 0;
    win_on = 1'b1;
    wr(ctl(1'b0, 3, 1'b0));
    #3000;
    win_on = 1'b0;
    check("R7 pulses seen during switch to reference", win_pulses > 0, 1);
    push_exp(128, "R7 reference path after switch");

    // R8: stop the reference while on the PLL path
    wr(ctl(1'b0, 3, 1'b1));
    #3000;
    @(negedge clk_fast);
    osc_run = 1'b0;
    repeat (40) @(negedge clk_fast);
    check("R8 no early loss detection", loss_flag, 0);
    repeat (60) @(negedge clk_fast);
    check("R8 loss detected", loss_flag, 1);
    check("R8 select cleared on loss", reg_rdata[0], 0);
    #500;
    r0 = rises;
    #2000;
    check("R8 no rising edges while reference absent", rises - r0, 0);
    check("R8 output held low", sys_clk, 0);

    // R9: sticky flag, ignored select, resumed reference path, reset clears
    wr(ctl(1'b0, 3, 1'b1));
    check("R9 select ignored while flag set", reg_rdata, ctl(1'b0, 3, 1'b0));
    osc_run = 1'b1;
    #3000;
    push_exp(128, "R9 reference path resumes");
    check("R9 flag still set after reference returns", loss_flag, 1);
    @(negedge clk_fast);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_fast);
    rst_n = 1'b1;
    @(negedge clk_fast);
    check("R9 reset clears loss flag", loss_flag, 0);
    check("R1 control word after second reset", reg_rdata, 5'h10);

    done = 1'b1;
    report();
  end
endmodule